// File: doc/BRIEF.md
# UART Receive Queue with Programmable Trigger

This block is the receive-side byte queue of a serial port. Bytes assembled by the receive shifter are pushed in one per cycle, and the host drains them through a receive-buffer read strobe. A control byte written by the host turns the queue mode on or off, flushes the receive queue on demand and picks one of four fill thresholds. When the threshold is reached, the block raises a trigger flag that the interrupt logic uses.

With the queue mode off, the block behaves as a single-byte holding register. It also raises a one-cycle overrun pulse whenever an incoming byte has no room. The decoded enable and threshold select are exported so that the transmit side can share the same control byte.

Top module: `rxq_trigger_fifo`

## Requirements
- R1: After reset the queue mode is off, the threshold select is 00, the queue is empty, fill_cnt is 0, and data_ready, trig_hit, q_full and overrun are all 0.
- R2: A control write sets fifo_en to bit 0 of the written byte, visible the cycle after the write. A write that changes fifo_en also empties the receive queue at that edge.
- R3: Control bits 7:6 and bit 1 act only when bit 0 of the same write is 1. A write with bit 0 = 0 leaves trig_sel unchanged.
- R4: A control write with bit 1 = 1 and bit 0 = 1 empties the receive queue at that edge, and a push in the same cycle is discarded without overrun. Bit 1 is not retained, so later pushes fill the queue normally.
- R5: trig_sel = bits 7:6 selects the threshold: 00 selects 1, 01 selects 4, 10 selects 8 and 11 selects 14 bytes. While the queue mode is on, trig_hit is 1 exactly while fill_cnt is at or above the selected threshold.
- R6: With the queue mode on, up to 16 bytes are held and read back in arrival order. fill_cnt reports the count, q_empty is set at 0 and q_full is set at 16.
- R7: With the queue mode off, capacity is one byte. data_ready, trig_hit and q_full are 1 while that byte is held.
- R8: A push while full, with no read in the same cycle, is dropped. overrun is 1 for exactly the following cycle, and fill_cnt is unchanged.
- R9: A read while empty leaves host_data and fill_cnt unchanged.
- R10: A read of a non-empty queue presents the oldest byte on host_data from the cycle after the read strobe.
- R11: A push and a read in the same cycle on a non-empty queue, including a full one, are both accepted and fill_cnt is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_we | input | 1 | Control byte write strobe |
| ctl_wdata | input | 8 | Control byte |
| rsr_push | input | 1 | Byte from receive shifter is valid |
| rsr_byte | input | DATA_W | Received byte |
| host_pop | input | 1 | Host receive-buffer read strobe |
| host_data | output | DATA_W | Byte returned by the last read |
| data_ready | output | 1 | At least one byte held |
| trig_hit | output | 1 | Fill count at or above threshold |
| q_empty | output | 1 | Queue empty |
| q_full | output | 1 | No room for another byte |
| fill_cnt | output | CNT_W | Number of bytes held |
| overrun | output | 1 | One-cycle pulse after a dropped byte |
| fifo_en | output | 1 | Decoded queue mode enable |
| trig_sel | output | 2 | Decoded threshold select |

## Verification
Every result of this block is due one edge after its stimulus. fill_cnt, q_empty, q_full, data_ready and trig_hit reflect a push, read, flush or threshold change right after that edge. host_data and overrun are registered and change at the same edge. The bench drives each stimulus after a falling edge and samples one falling edge later, so every check lands on the first cycle the result is due. For overrun, a second sample one cycle after that confirms the pulse has ended.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
   localparam int CTL_EN_BIT  = 0;
   localparam int CTL_CLR_BIT = 1;
   localparam int CTL_SEL_LSB = 6;

   typedef enum logic [1:0] {
      TRG_MIN  = 2'b00,
      TRG_LOW  = 2'b01,
      TRG_MID  = 2'b10,
      TRG_HIGH = 2'b11
   } trg_sel_e;

   function automatic int pick_level(trg_sel_e s, int l0, int l1, int l2, int l3);
      case (s)
         TRG_MIN:  return l0;
         TRG_LOW:  return l1;
         TRG_MID:  return l2;
         default:  return l3;
      endcase
   endfunction
endpackage

// File: rtl/rxq_ctl_reg.sv
module rxq_ctl_reg
   import rxq_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       we,
   input  logic [7:0] wdata,
   output logic       en,
   output trg_sel_e   sel,
   output logic       flush
);
   logic     en_q;
   trg_sel_e sel_q;
   logic     wr_on;
   logic     unused_bits;

   assign wr_on       = we && wdata[CTL_EN_BIT];
   assign unused_bits = ^wdata[5:2];

   // flush on explicit clear request or on any change of queue mode
   assign flush = (wr_on && wdata[CTL_CLR_BIT]) ||
                  (we && (wdata[CTL_EN_BIT] != en_q));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q  <= 1'b0;
         sel_q <= TRG_MIN;
      end else if (we) begin
         en_q <= wdata[CTL_EN_BIT];
         if (wr_on)
            sel_q <= trg_sel_e'(wdata[CTL_SEL_LSB +: 2]);
      end
   end

   assign en  = en_q;
   assign sel = sel_q;
endmodule

// File: rtl/rxq_store.sv
module rxq_store #(
   parameter int DATA_W = 8,
   parameter int DEPTH  = 16,
   localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flush,
   input  logic [CNT_W-1:0]  cap,
   input  logic              push,
   input  logic [DATA_W-1:0] wdata,
   input  logic              pop,
   output logic [DATA_W-1:0] rdata,
   output logic [CNT_W-1:0]  count,
   output logic              drop
);
   logic [DATA_W-1:0] mem [DEPTH];
   logic [AW-1:0]     wr_ptr, rd_ptr, wr_nxt, rd_nxt;
   logic [CNT_W-1:0]  cnt_q;
   logic              have_data, room, take_out, take_in, refuse;

   assign have_data = (cnt_q != '0);
   assign room      = (cnt_q < cap);
   assign take_out  = pop && have_data && !flush;
   assign take_in   = push && !flush && (room || take_out);
   assign refuse    = push && !flush && !(room || take_out);

   generate
      if ((DEPTH & (DEPTH - 1)) == 0) begin : g_pow2
         assign wr_nxt = wr_ptr + AW'(1);
         assign rd_nxt = rd_ptr + AW'(1);
      end else begin : g_wrap
         assign wr_nxt = (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + AW'(1);
         assign rd_nxt = (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + AW'(1);
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (take_in)
         mem[wr_ptr] <= wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         cnt_q  <= '0;
         rdata  <= '0;
         drop   <= 1'b0;
      end else begin
         drop <= refuse;
         if (flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt_q  <= '0;
         end else begin
            if (take_in)
               wr_ptr <= wr_nxt;
            if (take_out) begin
               rd_ptr <= rd_nxt;
               rdata  <= mem[rd_ptr];
            end
            case ({take_in, take_out})
               2'b10:   cnt_q <= cnt_q + CNT_W'(1);
               2'b01:   cnt_q <= cnt_q - CNT_W'(1);
               default: cnt_q <= cnt_q;
            endcase
         end
      end
   end

   assign count = cnt_q;
endmodule

// File: rtl/rxq_level_cmp.sv
module rxq_level_cmp
   import rxq_pkg::*;
#(
   parameter int DEPTH = 16,
   parameter int LVL0  = 1,
   parameter int LVL1  = 4,
   parameter int LVL2  = 8,
   parameter int LVL3  = 14,
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic [CNT_W-1:0] count,
   input  logic             en,
   input  trg_sel_e         sel,
   output logic             hit
);
   logic [CNT_W-1:0] level;

   always_comb begin
      if (en)
         level = CNT_W'(pick_level(sel, LVL0, LVL1, LVL2, LVL3));
      else
         level = CNT_W'(1);
   end

   assign hit = (count >= level);
endmodule

// File: rtl/rxq_trigger_fifo.sv
module rxq_trigger_fifo
   import rxq_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int DEPTH  = 16,
   parameter int LVL0   = 1,
   parameter int LVL1   = 4,
   parameter int LVL2   = 8,
   parameter int LVL3   = 14,
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ctl_we,
   input  logic [7:0]        ctl_wdata,
   input  logic              rsr_push,
   input  logic [DATA_W-1:0] rsr_byte,
   input  logic              host_pop,
   output logic [DATA_W-1:0] host_data,
   output logic              data_ready,
   output logic              trig_hit,
   output logic              q_empty,
   output logic              q_full,
   output logic [CNT_W-1:0]  fill_cnt,
   output logic              overrun,
   output logic              fifo_en,
   output logic [1:0]        trig_sel
);
   generate
      if (DEPTH < 2)
         $error("rxq_trigger_fifo: DEPTH must be at least 2");
      if (DATA_W < 1)
         $error("rxq_trigger_fifo: DATA_W must be positive");
      if (LVL0 < 1 || LVL0 > DEPTH || LVL1 < 1 || LVL1 > DEPTH ||
          LVL2 < 1 || LVL2 > DEPTH || LVL3 < 1 || LVL3 > DEPTH)
         $error("rxq_trigger_fifo: trigger levels must lie in 1..DEPTH");
   endgenerate

   trg_sel_e         sel_w;
   logic             flush_now;
   logic [CNT_W-1:0] cap_w;
   logic [CNT_W-1:0] cnt_w;

   rxq_ctl_reg u_ctl (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (ctl_we),
      .wdata (ctl_wdata),
      .en    (fifo_en),
      .sel   (sel_w),
      .flush (flush_now)
   );

   assign cap_w = fifo_en ? CNT_W'(DEPTH) : CNT_W'(1);

   rxq_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
      .clk   (clk),
      .rst_n (rst_n),
      .flush (flush_now),
      .cap   (cap_w),
      .push  (rsr_push),
      .wdata (rsr_byte),
      .pop   (host_pop),
      .rdata (host_data),
      .count (cnt_w),
      .drop  (overrun)
   );

   rxq_level_cmp #(
      .DEPTH(DEPTH), .LVL0(LVL0), .LVL1(LVL1), .LVL2(LVL2), .LVL3(LVL3)
   ) u_cmp (
      .count (cnt_w),
      .en    (fifo_en),
      .sel   (sel_w),
      .hit   (trig_hit)
   );

   assign fill_cnt   = cnt_w;
   assign q_empty    = (cnt_w == '0);
   assign data_ready = !q_empty;
   assign q_full     = (cnt_w >= cap_w);
   assign trig_sel   = sel_w;
endmodule

// File: rtl/rxq_checker.sv
module rxq_checker #(
   parameter int DEPTH  = 16,
   parameter int DATA_W = 8,
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              ctl_we,
   input logic [7:0]        ctl_wdata,
   input logic              rsr_push,
   input logic              host_pop,
   input logic [DATA_W-1:0] host_data,
   input logic              trig_hit,
   input logic              q_empty,
   input logic              q_full,
   input logic [CNT_W-1:0]  fill_cnt,
   input logic              overrun,
   input logic              fifo_en,
   input logic [1:0]        trig_sel,
   input logic              flush
);
   p_count_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
      int'(fill_cnt) <= DEPTH);

   p_full_empty_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !(q_full && q_empty));

   p_ctl_ignored_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_we && !ctl_wdata[0]) |=> $stable(trig_sel));

   p_clear_empties_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_we && ctl_wdata[0] && ctl_wdata[1]) |=> q_empty);

   p_trig_needs_data_r5: assert property (@(posedge clk) disable iff (!rst_n)
      trig_hit |-> !q_empty);

   p_disabled_cap_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !fifo_en |-> (int'(fill_cnt) <= 1));

   p_overrun_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (rsr_push && q_full && !host_pop && !flush) |=> (overrun && $stable(fill_cnt)));

   p_pop_empty_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (host_pop && q_empty && !rsr_push) |=> $stable(host_data));

   p_push_pop_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (rsr_push && host_pop && !q_empty && !flush) |=> $stable(fill_cnt));
endmodule

bind rxq_trigger_fifo rxq_checker #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .ctl_we    (ctl_we),
   .ctl_wdata (ctl_wdata),
   .rsr_push  (rsr_push),
   .host_pop  (host_pop),
   .host_data (host_data),
   .trig_hit  (trig_hit),
   .q_empty   (q_empty),
   .q_full    (q_full),
   .fill_cnt  (fill_cnt),
   .overrun   (overrun),
   .fifo_en   (fifo_en),
   .trig_sel  (trig_sel),
   .flush     (flush_now)
);

// File: tb/rxq_trigger_fifo_test.sv
module rxq_trigger_fifo_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ctl_we = 1'b0;
   logic [7:0] ctl_wdata = 8'h00;
   logic       rsr_push = 1'b0;
   logic [7:0] rsr_byte = 8'h00;
   logic       host_pop = 1'b0;
   logic [7:0] host_data;
   logic       data_ready, trig_hit, q_empty, q_full, overrun, fifo_en;
   logic [4:0] fill_cnt;
   logic [1:0] trig_sel;

   int tests = 0;
   int fails = 0;
   bit done  = 1'b0;

   always #5 clk = ~clk;

   rxq_trigger_fifo uut (
      .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
      .rsr_push(rsr_push), .rsr_byte(rsr_byte), .host_pop(host_pop),
      .host_data(host_data), .data_ready(data_ready), .trig_hit(trig_hit),
      .q_empty(q_empty), .q_full(q_full), .fill_cnt(fill_cnt),
      .overrun(overrun), .fifo_en(fifo_en), .trig_sel(trig_sel)
   );

   // vector: {op[1:0], arg[7:0], exp_cnt[4:0], exp_trig, exp_rd[7:0]}
   // op: 0 idle, 1 push, 2 read, 3 control write
   localparam int NV = 20;
   localparam logic [23:0] VEC [NV] = '{
      {2'd3, 8'h41, 5'd0, 1'b0, 8'h00},
      {2'd1, 8'h11, 5'd1, 1'b0, 8'h00},
      {2'd1, 8'h22, 5'd2, 1'b0, 8'h00},
      {2'd1, 8'h33, 5'd3, 1'b0, 8'h00},
      {2'd1, 8'h44, 5'd4, 1'b1, 8'h00},
      {2'd2, 8'h00, 5'd3, 1'b0, 8'h11},
      {2'd3, 8'h81, 5'd3, 1'b0, 8'h00},
      {2'd1, 8'h55, 5'd4, 1'b0, 8'h00},
      {2'd1, 8'h66, 5'd5, 1'b0, 8'h00},
      {2'd1, 8'h77, 5'd6, 1'b0, 8'h00},
      {2'd1, 8'h88, 5'd7, 1'b0, 8'h00},
      {2'd1, 8'h99, 5'd8, 1'b1, 8'h00},
      {2'd2, 8'h00, 5'd7, 1'b0, 8'h22},
      {2'd3, 8'h01, 5'd7, 1'b1, 8'h00},
      {2'd2, 8'h00, 5'd6, 1'b1, 8'h33},
      {2'd3, 8'hC1, 5'd6, 1'b0, 8'h00},
      {2'd3, 8'h03, 5'd0, 1'b0, 8'h00},
      {2'd1, 8'h5A, 5'd1, 1'b1, 8'h00},
      {2'd2, 8'h00, 5'd0, 1'b0, 8'h5A},
      {2'd0, 8'h00, 5'd0, 1'b0, 8'h00}
   };

   task automatic check(input int act, input int exp, input string what);
      tests++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", what, act, exp);
      end
   endtask

   // drive one cycle of stimulus after a falling edge, sample at the next one
   task automatic step(input bit we, input logic [7:0] wd, input bit push,
                       input logic [7:0] pd, input bit pop);
      ctl_we = we; ctl_wdata = wd; rsr_push = push; rsr_byte = pd; host_pop = pop;
      @(negedge clk);
      ctl_we = 1'b0; rsr_push = 1'b0; host_pop = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         fails++;
         tests++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      check(fifo_en, 0, "R1 fifo_en");
      check(trig_sel, 0, "R1 trig_sel");
      check(fill_cnt, 0, "R1 fill_cnt");
      check(q_empty, 1, "R1 q_empty");
      check({data_ready, trig_hit, q_full, overrun}, 0, "R1 flags");
      rst_n = 1'b1;
      @(negedge clk);

      // vector walk: R5 thresholds, R6 counts, R10 read data, R3/R4 control
      for (int i = 0; i < NV; i++) begin
         logic [1:0] op;
         logic [7:0] arg;
         op  = VEC[i][23:22];
         arg = VEC[i][21:14];
         step(op == 2'd3, arg, op == 2'd1, arg, op == 2'd2);
         check(fill_cnt, VEC[i][13:9], $sformatf("R6 count vec %0d", i));
         check(trig_hit, VEC[i][8], $sformatf("R5 trig vec %0d", i));
         if (op == 2'd2)
            check(host_data, VEC[i][7:0], $sformatf("R10 data vec %0d", i));
      end
      check(fifo_en, 1, "R2 enabled by table");

      // R5 threshold 14 edge and R6 full
      step(1, 8'hC1, 0, 0, 0);
      for (int k = 0; k < 16; k++) begin
         step(0, 0, 1, 8'h20 + 8'(k), 0);
         if (k == 12) check(trig_hit, 0, "R5 13 below 14");
         if (k == 13) check(trig_hit, 1, "R5 14 reached");
      end
      check(fill_cnt, 16, "R6 full count");
      check(q_full, 1, "R6 q_full");
      // R8 overrun
      step(0, 0, 1, 8'hEE, 0);
      check(overrun, 1, "R8 overrun pulse");
      check(fill_cnt, 16, "R8 count held");
      step(0, 0, 0, 0, 0);
      check(overrun, 0, "R8 pulse one cycle");
      // R11 push and read together while full
      step(0, 0, 1, 8'h70, 1);
      check(fill_cnt, 16, "R11 count unchanged");
      check(host_data, 8'h20, "R11 read data");
      check(overrun, 0, "R11 no overrun");
      // R6 order
      for (int k = 0; k < 16; k++) begin
         step(0, 0, 0, 0, 1);
         check(host_data, (k == 15) ? 8'h70 : 8'h21 + 8'(k), "R6 order");
      end
      check(q_empty, 1, "R6 empty after drain");
      // R9 read while empty
      step(0, 0, 0, 0, 1);
      check(host_data, 8'h70, "R9 data held");
      check(fill_cnt, 0, "R9 count held");

      // R3 bit0=0 write: select kept, mode off (R2)
      step(1, 8'h80, 0, 0, 0);
      check(trig_sel, 3, "R3 select kept");
      check(fifo_en, 0, "R2 mode off");
      // R7 holding register behaviour
      step(0, 0, 1, 8'h01, 0);
      check({data_ready, trig_hit, q_full}, 3'b111, "R7 holding flags");
      step(0, 0, 1, 8'h02, 0);
      check(overrun, 1, "R7 second byte overrun");
      check(fill_cnt, 1, "R7 capacity one");
      step(0, 0, 0, 0, 1);
      check(host_data, 8'h01, "R7 held byte");

      // R2 mode change flushes
      step(0, 0, 1, 8'h03, 0);
      step(1, 8'h01, 0, 0, 0);
      check(fill_cnt, 0, "R2 flush on enable");
      check(fifo_en, 1, "R2 mode on");
      check(trig_sel, 0, "R3 select updated");

      // R4 clear with push in same cycle, then not sticky
      step(0, 0, 1, 8'hAA, 0);
      step(1, 8'h03, 1, 8'hBB, 0);
      check(fill_cnt, 0, "R4 clear wins over push");
      check(overrun, 0, "R4 no overrun on clear");
      step(0, 0, 1, 8'hCC, 0);
      check(fill_cnt, 1, "R4 clear not sticky");
      step(0, 0, 0, 0, 1);
      check(host_data, 8'hCC, "R4 byte after clear");

      // R1 reset again mid-run
      step(0, 0, 1, 8'hDD, 0);
      rst_n = 1'b0;
      @(negedge clk);
      check(fill_cnt, 0, "R1 reset count");
      check(fifo_en, 0, "R1 reset mode");

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule